// File: doc/BRIEF.md
# Linear Flash Read Cache Sequencer

This block sits between a memory-mapped read port and a byte-wide serial flash path. It holds one line of 1024 bytes together with the bus address that line starts at. A read whose 4-byte window lies inside the line is answered in the same cycle: the four bytes starting at the read address are returned with the lowest address in the least significant byte. A read outside the line stalls the requester. The block then drives a read command to the flash, refills the whole line, records the new base and answers the read.

The command sent on a miss comes from a 32-bit linear-configuration register. It supplies the opcode, an optional mode byte, a count of dummy bytes and a dual-bus flag. When the dual-bus flag is set, two devices share each flash address, so the flash address is half the bus address. Bit 24 of the flash address chooses the upper or lower device page. The byte lanes, chip selects and striping live downstream and take a single byte stream with a request/acknowledge handshake.

Controller states: `ST_IDLE` serves hits and goes to `ST_FLUSH` on a miss. `ST_FLUSH` pulses the path flush for one cycle and then goes to `ST_OPC`. `ST_OPC` sends the opcode and moves on to `ST_ADR`. `ST_ADR` sends three address bytes, then goes to `ST_MODE` if the mode byte is enabled, else to `ST_DUMMY` if the dummy count is non-zero, else to `ST_FILL`. `ST_MODE` goes to `ST_DUMMY` or `ST_FILL` by the same dummy test. `ST_DUMMY` goes to `ST_FILL` after its last dummy byte. `ST_FILL` goes to `ST_DONE` after byte 1023. `ST_DONE` writes the base and returns to `ST_IDLE`.

Top module: `flash_line_cache`

## Requirements
- R1: The configuration register `cfg_q` reads 0x03A002EB after reset. A cycle with `cfg_we` high loads `cfg_wdata` into it, and the new value is visible on `cfg_q` from the next cycle.
- R2: While `rd_valid` is high and no refill is in progress, a read address A with base ≤ A ≤ base + 1020 raises `rd_ready` in the same cycle and causes no flash traffic.
- R3: Hit data is little-endian: `rd_data[8k+7:8k]` is the line byte at bus address A + k, for k = 0..3. Reads need not be word aligned.
- R4: On a miss, `path_flush` is high for exactly one cycle. The next flash bytes are the opcode `cfg_q[7:0]`, then the 24-bit flash address, most significant byte first.
- R5: After the address, the byte `cfg_q[23:16]` is sent only when `cfg_q[25]` is 1. Then as many 0x00 dummy bytes are sent as `cfg_q[10:8]` gives (0 to 7).
- R6: After the header, exactly 1024 bytes of 0x00 are sent. The received byte of fill transfer i becomes line byte i, and bytes received during the header are discarded. `burst_end` is high on the last transfer of each group of 64 fill bytes (fill index mod 64 = 63) and low on every other transfer.
- R7: When `cfg_q[30]` is 0, the flash address equals the bus address and the new base is that address. When it is 1, the flash address is the bus address shifted right by one and the base is twice the flash address.
- R8: `upper_page` equals bit 24 of the flash address while a header or fill byte is being requested, and is 0 whenever `xfer_req` is low.
- R9: The line is invalid after reset, and any configuration write invalidates it. The next read then misses even at an address that hit before.
- R10: Once `xfer_req` is high without `xfer_ack`, both `xfer_req` and `xfer_tx` hold their values until the acknowledge.
- R11: On a miss, `rd_ready` stays low until the refill has completed, and it is never high while a flash byte is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write value |
| cfg_q | output | 32 | Current configuration value |
| rd_valid | input | 1 | Read request held until accepted |
| rd_addr | input | ADDR_W (25) | Read byte address |
| rd_ready | output | 1 | Read accepted, `rd_data` valid this cycle |
| rd_data | output | 32 | Little-endian read word |
| xfer_req | output | 1 | Flash byte transfer request |
| xfer_tx | output | 8 | Byte to send to the flash |
| xfer_ack | input | 1 | Transfer completes at this clock edge |
| xfer_rx | input | 8 | Byte received with the acknowledge |
| burst_end | output | 1 | Last transfer of a 64-byte fill group |
| path_flush | output | 1 | One-cycle pulse that empties the downstream queues |
| upper_page | output | 1 | Upper device page selected during a sequence |

## Verification
Reads are run against a flash model. The model stalls every fifth transfer, returns a known byte for each address during the fill, and returns a junk byte during the header. A miss followed by reads at the base, at base + 1020 and at an unaligned offset tells a correct hit window and byte order apart from off-by-one bounds or swapped lanes. A read at base + 1021 must miss. Four configurations are exercised: the reset default with mode byte and two dummies, no mode and no dummies, dual-bus with five dummies, and mode byte without dummies. Each exposes a different header length and address mapping. A read at an address above 2^24 shows that the page select follows the flash address, and rereading a cached address after a configuration write shows that the line is invalidated.

// File: rtl/flc_pkg.sv
package flc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FLUSH,
        ST_OPC,
        ST_ADR,
        ST_MODE,
        ST_DUMMY,
        ST_FILL,
        ST_DONE
    } flc_state_t;

    localparam logic [31:0] CFG_RESET_VAL = 32'h03A0_02EB;

    function automatic logic [7:0] cfg_opcode(input logic [31:0] c);
        return c[7:0];
    endfunction

    function automatic logic [7:0] cfg_mode_byte(input logic [31:0] c);
        return c[23:16];
    endfunction

    function automatic logic cfg_mode_en(input logic [31:0] c);
        return c[25];
    endfunction

    function automatic logic [2:0] cfg_dummy(input logic [31:0] c);
        return c[10:8];
    endfunction

    function automatic logic cfg_dual(input logic [31:0] c);
        return c[30];
    endfunction

endpackage

// File: rtl/flc_hit.sv
module flc_hit #(
    parameter int ADDR_W     = 25,
    parameter int LINE_BYTES = 1024,
    parameter int RD_BYTES   = 4
) (
    input  logic [ADDR_W-1:0]             addr,
    input  logic [ADDR_W:0]               base,
    output logic                          hit,
    output logic [$clog2(LINE_BYTES)-1:0] off
);
    localparam int OFF_W = $clog2(LINE_BYTES);
    localparam int EXT_W = ADDR_W + 2;

    logic [EXT_W-1:0] addr_x;
    logic [EXT_W-1:0] lo_x;
    logic [EXT_W-1:0] hi_x;

    always_comb begin
        addr_x = EXT_W'(addr);
        lo_x   = EXT_W'(base);
        hi_x   = lo_x + EXT_W'(LINE_BYTES - RD_BYTES);
        hit    = (addr_x >= lo_x) && (addr_x <= hi_x);
        off    = addr[OFF_W-1:0] - base[OFF_W-1:0];
    end
endmodule

// File: rtl/flc_line_buf.sv
module flc_line_buf #(
    parameter int LINE_BYTES = 1024,
    parameter int RD_BYTES   = 4
) (
    input  logic                          clk,
    input  logic                          we,
    input  logic [$clog2(LINE_BYTES)-1:0] widx,
    input  logic [7:0]                    wdata,
    input  logic [$clog2(LINE_BYTES)-1:0] roff,
    output logic [8*RD_BYTES-1:0]         rdata
);
    localparam int OFF_W = $clog2(LINE_BYTES);

    logic [7:0] mem [LINE_BYTES];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[widx] <= wdata;
        end
    end

    for (genvar k = 0; k < RD_BYTES; k++) begin : g_lane
        assign rdata[8*k +: 8] = mem[roff + OFF_W'(k)];
    end
endmodule

// File: rtl/flc_seq.sv
module flc_seq
    import flc_pkg::*;
#(
    parameter int ADDR_W      = 25,
    parameter int LINE_BYTES  = 1024,
    parameter int BURST_BYTES = 64,
    parameter int DEV_BITS    = 24
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic [ADDR_W-1:0]             miss_addr,
    input  logic [7:0]                    opc,
    input  logic [7:0]                    mode_byte,
    input  logic                          mode_en,
    input  logic [2:0]                    dummy,
    input  logic                          dual,
    input  logic                          xfer_ack,
    output logic                          idle,
    output logic                          done,
    output logic [ADDR_W:0]               new_base,
    output logic                          xfer_req,
    output logic [7:0]                    xfer_tx,
    output logic                          burst_end,
    output logic                          path_flush,
    output logic                          upper_page,
    output logic                          buf_we,
    output logic [$clog2(LINE_BYTES)-1:0] buf_idx
);
    localparam int OFF_W     = $clog2(LINE_BYTES);
    localparam int BURST_W   = $clog2(BURST_BYTES);
    localparam int ADR_BYTES = DEV_BITS / 8;

    flc_state_t        state_q, state_d;
    logic [OFF_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] faddr_q;
    logic [7:0]        opc_q, mode_q;
    logic              mode_en_q, dual_q;
    logic [2:0]        dummy_q;
    logic              step;

    assign step = xfer_req && xfer_ack;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_FLUSH;
            ST_FLUSH: state_d = ST_OPC;
            ST_OPC:   if (step) state_d = ST_ADR;
            ST_ADR: begin
                if (step && cnt_q == OFF_W'(ADR_BYTES - 1)) begin
                    if (mode_en_q)           state_d = ST_MODE;
                    else if (dummy_q != '0)  state_d = ST_DUMMY;
                    else                     state_d = ST_FILL;
                end
            end
            ST_MODE: begin
                if (step) state_d = (dummy_q != '0) ? ST_DUMMY : ST_FILL;
            end
            ST_DUMMY: begin
                if (step && cnt_q == OFF_W'(dummy_q) - OFF_W'(1)) state_d = ST_FILL;
            end
            ST_FILL: begin
                if (step && cnt_q == OFF_W'(LINE_BYTES - 1)) state_d = ST_DONE;
            end
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cnt_q     <= '0;
            faddr_q   <= '0;
            opc_q     <= '0;
            mode_q    <= '0;
            mode_en_q <= 1'b0;
            dummy_q   <= '0;
            dual_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q) begin
                cnt_q <= '0;
            end else if (step) begin
                cnt_q <= cnt_q + OFF_W'(1);
            end
            if (state_q == ST_IDLE && start) begin
                faddr_q   <= dual ? (miss_addr >> 1) : miss_addr;
                opc_q     <= opc;
                mode_q    <= mode_byte;
                mode_en_q <= mode_en;
                dummy_q   <= dummy;
                dual_q    <= dual;
            end
        end
    end

    // outputs
    always_comb begin
        idle       = 1'b0;
        done       = 1'b0;
        xfer_req   = 1'b0;
        xfer_tx    = 8'h00;
        burst_end  = 1'b0;
        path_flush = 1'b0;
        buf_we     = 1'b0;
        unique case (state_q)
            ST_IDLE:  idle = 1'b1;
            ST_FLUSH: path_flush = 1'b1;
            ST_OPC: begin
                xfer_req = 1'b1;
                xfer_tx  = opc_q;
            end
            ST_ADR: begin
                xfer_req = 1'b1;
                xfer_tx  = 8'(faddr_q >> (8 * (ADR_BYTES - 1 - int'(cnt_q))));
            end
            ST_MODE: begin
                xfer_req = 1'b1;
                xfer_tx  = mode_q;
            end
            ST_DUMMY: xfer_req = 1'b1;
            ST_FILL: begin
                xfer_req  = 1'b1;
                burst_end = &cnt_q[BURST_W-1:0];
                buf_we    = xfer_ack;
            end
            ST_DONE:  done = 1'b1;
            default:  idle = 1'b0;
        endcase
        upper_page = xfer_req && faddr_q[DEV_BITS];
        buf_idx    = cnt_q;
        new_base   = dual_q ? {1'b0, faddr_q[ADDR_W-2:0], 1'b0} : {1'b0, faddr_q};
    end
endmodule

// File: rtl/flash_line_cache.sv
module flash_line_cache
    import flc_pkg::*;
#(
    parameter int ADDR_W      = 25,
    parameter int LINE_BYTES  = 1024,
    parameter int BURST_BYTES = 64,
    parameter int DEV_BITS    = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_q,
    input  logic              rd_valid,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_ready,
    output logic [31:0]       rd_data,
    output logic              xfer_req,
    output logic [7:0]        xfer_tx,
    input  logic              xfer_ack,
    input  logic [7:0]        xfer_rx,
    output logic              burst_end,
    output logic              path_flush,
    output logic              upper_page
);
    localparam int OFF_W    = $clog2(LINE_BYTES);
    localparam int RD_BYTES = 4;

    logic [ADDR_W:0]  base_q;
    logic [ADDR_W:0]  new_base;
    logic             hit, idle, done, buf_we;
    logic [OFF_W-1:0] off, buf_idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q  <= CFG_RESET_VAL;
            base_q <= '1;
        end else begin
            if (cfg_we) begin
                cfg_q  <= cfg_wdata;
                base_q <= '1;
            end else if (done) begin
                base_q <= new_base;
            end
        end
    end

    flc_hit #(
        .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .RD_BYTES(RD_BYTES)
    ) u_hit (
        .addr(rd_addr), .base(base_q), .hit(hit), .off(off)
    );

    flc_line_buf #(
        .LINE_BYTES(LINE_BYTES), .RD_BYTES(RD_BYTES)
    ) u_buf (
        .clk(clk), .we(buf_we), .widx(buf_idx), .wdata(xfer_rx),
        .roff(off), .rdata(rd_data)
    );

    flc_seq #(
        .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES),
        .BURST_BYTES(BURST_BYTES), .DEV_BITS(DEV_BITS)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .start(rd_valid && !hit),
        .miss_addr(rd_addr),
        .opc(cfg_opcode(cfg_q)),
        .mode_byte(cfg_mode_byte(cfg_q)),
        .mode_en(cfg_mode_en(cfg_q)),
        .dummy(cfg_dummy(cfg_q)),
        .dual(cfg_dual(cfg_q)),
        .xfer_ack(xfer_ack),
        .idle(idle), .done(done), .new_base(new_base),
        .xfer_req(xfer_req), .xfer_tx(xfer_tx), .burst_end(burst_end),
        .path_flush(path_flush), .upper_page(upper_page),
        .buf_we(buf_we), .buf_idx(buf_idx)
    );

    assign rd_ready = rd_valid && hit && idle;
endmodule

// File: rtl/flash_line_cache_chk.sv
module flash_line_cache_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_valid,
    input logic       rd_ready,
    input logic       xfer_req,
    input logic       xfer_ack,
    input logic [7:0] xfer_tx,
    input logic       burst_end,
    input logic       path_flush,
    input logic       upper_page
);
    p_hold_tx_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && !xfer_ack) |=> (xfer_req && $stable(xfer_tx)));

    p_no_ready_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ready |-> !xfer_req);

    p_ready_needs_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ready |-> rd_valid);

    p_flush_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        path_flush |=> (!path_flush && xfer_req));

    p_burst_in_xfer_r6: assert property (@(posedge clk) disable iff (!rst_n)
        burst_end |-> xfer_req);

    p_page_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_req |-> !upper_page);
endmodule

bind flash_line_cache flash_line_cache_chk u_chk (
    .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .xfer_req(xfer_req), .xfer_ack(xfer_ack), .xfer_tx(xfer_tx),
    .burst_end(burst_end), .path_flush(path_flush), .upper_page(upper_page)
);

// File: tb/flash_line_cache_tb.sv
`timescale 1ns/1ps
module flash_line_cache_tb;
    localparam int ADDR_W = 25;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [31:0]       cfg_wdata = '0;
    logic [31:0]       cfg_q;
    logic              rd_valid = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic              rd_ready;
    logic [31:0]       rd_data;
    logic              xfer_req;
    logic [7:0]        xfer_tx;
    logic              xfer_ack = 1'b0;
    logic [7:0]        xfer_rx = '0;
    logic              burst_end, path_flush, upper_page;

    int checks = 0;
    int errors = 0;

    // bench view of the configuration
    logic [7:0]  b_opc = 8'hEB, b_mode = 8'hA0;
    bit          b_mode_en = 1'b1, b_dual = 1'b0;
    int          b_dummy = 2;
    // bench view of the line
    bit          mvalid = 1'b0;
    int unsigned mbase = 0;
    // per-miss expectations used by the monitor
    int unsigned exp_base = 0;
    bit          exp_page = 1'b0;
    int          hdr_len = 0;
    int          idx = 0;
    int          stall_ctr = 0;
    bit          prev_stall = 1'b0;
    logic [7:0]  prev_tx = '0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;

    flash_line_cache u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_q(cfg_q), .rd_valid(rd_valid), .rd_addr(rd_addr),
        .rd_ready(rd_ready), .rd_data(rd_data), .xfer_req(xfer_req),
        .xfer_tx(xfer_tx), .xfer_ack(xfer_ack), .xfer_rx(xfer_rx),
        .burst_end(burst_end), .path_flush(path_flush), .upper_page(upper_page)
    );

    function automatic logic [7:0] memfn(input int unsigned a);
        return 8'((a * 13) ^ (a >> 7) ^ 32'h5A);
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor / flash model: scoreboard pops expected bytes
    always @(negedge clk) begin
        if (path_flush) begin
            idx = 0;
        end
        if (prev_stall) begin
            chk(xfer_req && xfer_tx == prev_tx, "R10", {xfer_req, xfer_tx}, {1'b1, prev_tx});
        end
        if (xfer_req) begin
            stall_ctr++;
            xfer_ack = (stall_ctr % 5) != 3;
            if (idx < hdr_len) xfer_rx = 8'hEE;
            else               xfer_rx = memfn(exp_base + idx - hdr_len);
            if (xfer_ack) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2 unexpected flash byte", xfer_tx, 0);
                end else begin
                    automatic logic [7:0] e = exp_q.pop_front();
                    automatic string t = tag_q.pop_front();
                    chk(xfer_tx == e, t, xfer_tx, e);
                end
                chk(upper_page == exp_page, "R8", upper_page, exp_page);
                if (idx >= hdr_len) begin
                    chk(burst_end == (((idx - hdr_len) % 64) == 63), "R6 burst_end",
                        burst_end, (((idx - hdr_len) % 64) == 63));
                end
                idx++;
            end
            prev_stall = !xfer_ack;
            prev_tx    = xfer_tx;
        end else begin
            xfer_ack   = 1'b0;
            prev_stall = 1'b0;
        end
    end

    task automatic write_cfg(input logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        chk(cfg_q == v, "R1 cfg write", cfg_q, v);
        b_opc = v[7:0];
        b_mode = v[23:16];
        b_mode_en = v[25];
        b_dummy = int'(v[10:8]);
        b_dual = v[30];
        mvalid = 1'b0;   // R9: any write invalidates
    endtask

    task automatic do_read(input int unsigned a, input string why);
        automatic bit exp_hit = mvalid && a >= mbase && a <= mbase + 1020;
        automatic int unsigned fa;
        automatic int n = 0;
        automatic logic [31:0] ed;
        if (!exp_hit) begin
            fa = b_dual ? (a >> 1) : a;
            exp_q.push_back(b_opc);                  tag_q.push_back("R4 opcode");
            exp_q.push_back(8'(fa >> 16));           tag_q.push_back("R4 addr hi");
            exp_q.push_back(8'(fa >> 8));            tag_q.push_back("R4 addr mid");
            exp_q.push_back(8'(fa));                 tag_q.push_back("R4 addr lo");
            hdr_len = 4;
            if (b_mode_en) begin
                exp_q.push_back(b_mode);             tag_q.push_back("R5 mode");
                hdr_len++;
            end
            for (int d = 0; d < b_dummy; d++) begin
                exp_q.push_back(8'h00);              tag_q.push_back("R5 dummy");
                hdr_len++;
            end
            for (int f = 0; f < 1024; f++) begin
                exp_q.push_back(8'h00);              tag_q.push_back("R6 fill tx");
            end
            exp_base = b_dual ? fa * 2 : fa;   // R7
            exp_page = ((fa >> 24) & 1) != 0;
        end
        @(negedge clk);
        rd_valid = 1'b1;
        rd_addr = ADDR_W'(a);
        #1;
        if (exp_hit) chk(rd_ready == 1'b1, {"R2 hit ", why}, rd_ready, 1);
        else         chk(rd_ready == 1'b0, {"R11 stall ", why}, rd_ready, 0);
        while (!rd_ready && n < 5000) begin
            @(negedge clk);
            #1;
            n++;
        end
        chk(n < 5000, {"R11 refill completes ", why}, n, 5000);
        ed = {memfn(a + 3), memfn(a + 2), memfn(a + 1), memfn(a)};
        chk(rd_data == ed, {"R3 data ", why}, rd_data, ed);
        chk(exp_q.size() == 0, {"R4 header/fill length ", why}, exp_q.size(), 0);
        chk(upper_page == 1'b0, "R8 idle page", upper_page, 0);
        if (!exp_hit) begin
            mvalid = 1'b1;
            mbase = exp_base;
        end
        @(negedge clk);
        rd_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cfg_q == 32'h03A002EB, "R1 reset cfg", cfg_q, 32'h03A002EB);
        chk(rd_ready == 1'b0 && xfer_req == 1'b0, "R11 reset idle", {rd_ready, xfer_req}, 0);

        // reset default: opcode EB, mode A0, two dummies; invalid after reset (R9)
        do_read(32'h000100, "R9 first miss");
        do_read(32'h000100, "base");
        do_read(32'h000100 + 1020, "upper bound");
        do_read(32'h000101, "unaligned");
        do_read(32'h000100 + 1021, "past bound miss");
        do_read(32'h0000FF, "below base miss");

        // no mode byte, no dummies (R5)
        write_cfg(32'h0000_0003);
        do_read(32'h0000FF, "R9 reread after cfg write");
        do_read(32'h0000FF + 17, "hit after cfg miss");

        // upper device page (R8)
        do_read(32'h1000010, "R8 upper page");
        do_read(32'h1000012, "upper page hit");

        // dual bus, five dummies (R7)
        write_cfg(32'h4000_053B);
        do_read(32'h1000021, "R7 dual odd addr");
        do_read(32'h1000020, "R7 dual base even");
        do_read(32'h1000020 + 1020, "R7 dual bound");

        // mode byte without dummies (R5)
        write_cfg(32'h0255_0022);
        do_read(32'h000003, "R5 mode no dummy");
        do_read(32'h000203, "R6 mid line");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule